// File: doc/BRIEF.md
# Nibble-Stream Ethernet Receive Frame Checker

This block sits behind a 4-bit media-independent receive interface and turns the nibble stream of each incoming frame into bytes. It hunts for the preamble and the start-of-frame delimiter, then assembles each byte from a low nibble followed by a high nibble. A CRC-32 runs over every received nibble, and when the data-valid line drops the block gives a one-cycle verdict saying whether the frame may be kept.

Bytes are forwarded downstream as they are assembled, held back by four bytes. The four frame-check bytes are therefore never forwarded. The downstream consumer stores the forwarded bytes and keeps or discards them on the verdict. Frames with a bad check sequence, undersized frames and frames that end on half a byte are rejected, and each kind has its own saturating counter. An optional destination filter accepts frames for the station address and broadcast frames only.

Top module: `mii_rx_fcs_check`

## Requirements
- R1: After reset `out_valid`, `out_first`, `frame_done` and `frame_ok` are 0 and all three error counters read 0.
- R2: While `rx_dv` is high the block waits for one or more 0x5 nibbles followed by a 0xD nibble, and byte assembly starts with the next nibble. Any other nibble before that 0xD makes the block ignore the rest of the frame: no bytes, no verdict and no counter change.
- R3: Each data byte is built from two consecutive nibbles. The first nibble is bits 3:0 and the second is bits 7:4.
- R4: A frame of N bytes after the delimiter forwards exactly its first N-4 bytes, in order, one `out_valid` pulse per byte. `out_first` is high with the first of them only.
- R5: The frame check uses the reflected CRC-32 (generator 0x04C11DB7), preset to all ones and run over every byte after the delimiter, including the four check bytes. A frame is good only if the register then holds 0xDEBB20E3. An otherwise valid frame that fails this gives `frame_ok`=0 and increments `crc_err_cnt`.
- R6: A frame shorter than MIN_BYTES (default 64, check bytes included) gives `frame_ok`=0 and increments `runt_cnt`. A frame of exactly MIN_BYTES can be accepted.
- R7: A frame that ends after an odd number of data nibbles gives `frame_ok`=0 and increments `align_err_cnt`.
- R8: With ADDR_FILTER=1, the first six bytes are the destination address, and the first byte received is compared with `station_addr[47:40]`. An address equal to `station_addr`, or all ones, may be accepted. Any other address gives `frame_ok`=0 and changes no counter.
- R9: `frame_done` is a one-cycle pulse. It rises one clock after the first rising edge that samples `rx_dv` low at the end of a frame. `frame_ok` is high only together with `frame_done`.
- R10: A rejected frame increments at most one counter. An alignment error takes precedence over a runt, and a runt takes precedence over a check-sequence error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_nib | input | 4 | Receive data nibble |
| station_addr | input | 48 | Local address, first byte received in bits 47:40 |
| out_data | output | 8 | Forwarded frame byte |
| out_valid | output | 1 | `out_data` holds a new byte |
| out_first | output | 1 | Marks the first forwarded byte of a frame |
| frame_done | output | 1 | End-of-frame verdict strobe |
| frame_ok | output | 1 | Verdict: frame may be kept |
| crc_err_cnt | output | CNT_W | Frames with a bad check sequence |
| runt_cnt | output | CNT_W | Undersized frames |
| align_err_cnt | output | CNT_W | Frames ending on half a byte |

## Verification
A wrong nibble phase or a wrong delimiter position shifts every forwarded byte, so the byte stream differs from the sent payload at its first byte. A CRC register that was not preset, or that was updated in the wrong bit order, reaches the ports only at the verdict, one clock after the frame ends. Good frames then show up as check-sequence errors in `crc_err_cnt`. A stale length or address register shows up in the same verdict cycle, either as a wrongly accepted runt or foreign frame, or as the wrong counter moving.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_DATA = 2'd1,
      ST_DROP = 2'd2
   } mrx_state_e;

   localparam logic [3:0]  PRE_NIB     = 4'h5;
   localparam logic [3:0]  SFD_NIB     = 4'hD;
   localparam int          FCS_BYTES   = 4;
   localparam int          ADDR_BYTES  = 6;
   localparam logic [31:0] POLY_REFL   = 32'hEDB8_8320;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

   // advance a reflected CRC-32 register by four data bits, LSB first
   function automatic logic [31:0] crc_nib_step(input logic [31:0] c_in,
                                                input logic [3:0]  nib);
      logic [31:0] c;
      c = c_in;
      for (int b = 0; b < 4; b++) begin
         if (c[0] ^ nib[b]) c = (c >> 1) ^ POLY_REFL;
         else               c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/mrx_nib_deframer.sv
module mrx_nib_deframer
   import mrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_dv,
   input  logic [3:0] rx_nib,
   output logic       sfd_stb,
   output logic       nib_stb,
   output logic [3:0] nib_q,
   output logic       byte_stb,
   output logic [7:0] byte_q,
   output logic       end_stb,
   output logic       end_odd
);

   mrx_state_e state;
   logic       seen_pre;
   logic       phase;
   logic [3:0] lo_nib;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_HUNT;
         seen_pre <= 1'b0;
         phase    <= 1'b0;
         lo_nib   <= '0;
         sfd_stb  <= 1'b0;
         nib_stb  <= 1'b0;
         nib_q    <= '0;
         byte_stb <= 1'b0;
         byte_q   <= '0;
         end_stb  <= 1'b0;
         end_odd  <= 1'b0;
      end else begin
         sfd_stb  <= 1'b0;
         nib_stb  <= 1'b0;
         byte_stb <= 1'b0;
         end_stb  <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (!rx_dv) begin
                  seen_pre <= 1'b0;
               end else if (rx_nib == SFD_NIB && seen_pre) begin
                  state    <= ST_DATA;
                  sfd_stb  <= 1'b1;
                  phase    <= 1'b0;
                  seen_pre <= 1'b0;
               end else if (rx_nib == PRE_NIB) begin
                  seen_pre <= 1'b1;
               end else begin
                  state    <= ST_DROP;
                  seen_pre <= 1'b0;
               end
            end
            ST_DATA: begin
               if (rx_dv) begin
                  nib_stb <= 1'b1;
                  nib_q   <= rx_nib;
                  phase   <= ~phase;
                  if (!phase) begin
                     lo_nib <= rx_nib;
                  end else begin
                     byte_stb <= 1'b1;
                     byte_q   <= {rx_nib, lo_nib};
                  end
               end else begin
                  end_stb <= 1'b1;
                  end_odd <= phase;
                  state   <= ST_HUNT;
               end
            end
            default: begin
               if (!rx_dv) state <= ST_HUNT;
            end
         endcase
      end
   end

endmodule

// File: rtl/mrx_crc_nib.sv
module mrx_crc_nib
   import mrx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        preset,
   input  logic        nib_stb,
   input  logic [3:0]  nib,
   output logic [31:0] crc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= '1;
      else if (preset)  crc_q <= '1;
      else if (nib_stb) crc_q <= crc_nib_step(crc_q, nib);
   end

endmodule

// File: rtl/mrx_holdback.sv
module mrx_holdback
   import mrx_pkg::*;
#(
   parameter int DEPTH = FCS_BYTES
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       byte_stb,
   input  logic [7:0] byte_in,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_first
);

   localparam int FW = $clog2(DEPTH + 1);

   logic [7:0]    pipe [DEPTH];
   logic [FW-1:0] fill;
   logic          first_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else if (byte_stb) pipe[0] <= byte_in;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= '0;
         else if (byte_stb) pipe[i] <= pipe[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill       <= '0;
         first_pend <= 1'b0;
         out_data   <= '0;
         out_valid  <= 1'b0;
         out_first  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         if (restart) begin
            fill       <= '0;
            first_pend <= 1'b1;
         end else if (byte_stb) begin
            if (fill == FW'(DEPTH)) begin
               out_valid  <= 1'b1;
               out_data   <= pipe[DEPTH-1];
               out_first  <= first_pend;
               first_pend <= 1'b0;
            end else begin
               fill <= fill + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mrx_verdict.sv
module mrx_verdict
   import mrx_pkg::*;
#(
   parameter int MIN_BYTES   = 64,
   parameter int LEN_W       = 16,
   parameter int CNT_W       = 16,
   parameter bit ADDR_FILTER = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             byte_stb,
   input  logic [7:0]       byte_in,
   input  logic             end_stb,
   input  logic             end_odd,
   input  logic [31:0]      crc_q,
   input  logic [47:0]      station_addr,
   output logic             frame_done,
   output logic             frame_ok,
   output logic [CNT_W-1:0] crc_err_cnt,
   output logic [CNT_W-1:0] runt_cnt,
   output logic [CNT_W-1:0] align_err_cnt
);

   localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_BYTES);
   localparam logic [LEN_W-1:0] LEN_ADDR = LEN_W'(ADDR_BYTES);

   logic [LEN_W-1:0] len;
   logic [47:0]      dst;
   logic             addr_ok;
   logic             short_frm;
   logic             crc_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len <= '0;
         dst <= '0;
      end else if (restart) begin
         len <= '0;
      end else if (byte_stb) begin
         if (!(&len)) len <= len + 1'b1;
         if (len < LEN_ADDR) dst <= {dst[39:0], byte_in};
      end
   end

   if (ADDR_FILTER) begin : g_filter
      assign addr_ok = (dst == station_addr) || (&dst);
   end else begin : g_promisc
      assign addr_ok = 1'b1;
   end

   assign short_frm = (len < LEN_MIN);
   assign crc_bad   = (crc_q != CRC_RESIDUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_done    <= 1'b0;
         frame_ok      <= 1'b0;
         crc_err_cnt   <= '0;
         runt_cnt      <= '0;
         align_err_cnt <= '0;
      end else begin
         frame_done <= 1'b0;
         frame_ok   <= 1'b0;
         if (end_stb) begin
            frame_done <= 1'b1;
            frame_ok   <= !end_odd && !short_frm && !crc_bad && addr_ok;
            if (end_odd) begin
               if (!(&align_err_cnt)) align_err_cnt <= align_err_cnt + 1'b1;
            end else if (short_frm) begin
               if (!(&runt_cnt)) runt_cnt <= runt_cnt + 1'b1;
            end else if (crc_bad) begin
               if (!(&crc_err_cnt)) crc_err_cnt <= crc_err_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mii_rx_fcs_check.sv
module mii_rx_fcs_check
   import mrx_pkg::*;
#(
   parameter int MIN_BYTES   = 64,
   parameter int LEN_W       = 16,
   parameter int CNT_W       = 16,
   parameter bit ADDR_FILTER = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_dv,
   input  logic [3:0]       rx_nib,
   input  logic [47:0]      station_addr,
   output logic [7:0]       out_data,
   output logic             out_valid,
   output logic             out_first,
   output logic             frame_done,
   output logic             frame_ok,
   output logic [CNT_W-1:0] crc_err_cnt,
   output logic [CNT_W-1:0] runt_cnt,
   output logic [CNT_W-1:0] align_err_cnt
);

   if (MIN_BYTES < FCS_BYTES + 1) begin : g_bad_min
      $error("MIN_BYTES must exceed the check sequence length");
   end
   if (LEN_W < 3 || MIN_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for MIN_BYTES");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic        sfd_stb;
   logic        nib_stb;
   logic [3:0]  nib_q;
   logic        byte_stb;
   logic [7:0]  byte_q;
   logic        end_stb;
   logic        end_odd;
   logic [31:0] crc_q;

   mrx_nib_deframer u_deframer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_dv    (rx_dv),
      .rx_nib   (rx_nib),
      .sfd_stb  (sfd_stb),
      .nib_stb  (nib_stb),
      .nib_q    (nib_q),
      .byte_stb (byte_stb),
      .byte_q   (byte_q),
      .end_stb  (end_stb),
      .end_odd  (end_odd)
   );

   mrx_crc_nib u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .preset  (sfd_stb),
      .nib_stb (nib_stb),
      .nib     (nib_q),
      .crc_q   (crc_q)
   );

   mrx_holdback #(.DEPTH(FCS_BYTES)) u_holdback (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (sfd_stb),
      .byte_stb  (byte_stb),
      .byte_in   (byte_q),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_first (out_first)
   );

   mrx_verdict #(
      .MIN_BYTES   (MIN_BYTES),
      .LEN_W       (LEN_W),
      .CNT_W       (CNT_W),
      .ADDR_FILTER (ADDR_FILTER)
   ) u_verdict (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart       (sfd_stb),
      .byte_stb      (byte_stb),
      .byte_in       (byte_q),
      .end_stb       (end_stb),
      .end_odd       (end_odd),
      .crc_q         (crc_q),
      .station_addr  (station_addr),
      .frame_done    (frame_done),
      .frame_ok      (frame_ok),
      .crc_err_cnt   (crc_err_cnt),
      .runt_cnt      (runt_cnt),
      .align_err_cnt (align_err_cnt)
   );

endmodule

// File: rtl/mrx_rx_checker.sv
module mrx_rx_checker #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             rx_dv,
   input logic             out_valid,
   input logic             out_first,
   input logic             frame_done,
   input logic             frame_ok,
   input logic [CNT_W-1:0] crc_err_cnt,
   input logic [CNT_W-1:0] runt_cnt,
   input logic [CNT_W-1:0] align_err_cnt
);

   a_r9_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |-> frame_done);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r9_done_after_dv_low: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !$past(rx_dv, 2));

   a_r4_first_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid);

   a_r5_crc_cnt_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err_cnt != $past(crc_err_cnt)) |-> (frame_done && !frame_ok));

   a_r6_runt_cnt_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (runt_cnt != $past(runt_cnt)) |-> (frame_done && !frame_ok));

   a_r7_align_cnt_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (align_err_cnt != $past(align_err_cnt)) |-> (frame_done && !frame_ok));

   a_r10_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({crc_err_cnt != $past(crc_err_cnt),
                runt_cnt != $past(runt_cnt),
                align_err_cnt != $past(align_err_cnt)}));

endmodule

bind mii_rx_fcs_check mrx_rx_checker #(.CNT_W(CNT_W)) u_rx_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_dv         (rx_dv),
   .out_valid     (out_valid),
   .out_first     (out_first),
   .frame_done    (frame_done),
   .frame_ok      (frame_ok),
   .crc_err_cnt   (crc_err_cnt),
   .runt_cnt      (runt_cnt),
   .align_err_cnt (align_err_cnt)
);

// File: tb/mii_rx_fcs_check_bench.sv
`timescale 1ns/1ps
module mii_rx_fcs_check_bench;

   localparam logic [47:0] STATION = 48'h021E_A53C_77D1;
   localparam logic [47:0] FOREIGN = 48'h021E_A53C_77D0;
   localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_dv = 1'b0;
   logic [3:0]  rx_nib = '0;
   logic [7:0]  out_data;
   logic        out_valid, out_first, frame_done, frame_ok;
   logic [15:0] crc_err_cnt, runt_cnt, align_err_cnt;

   always #2.5 clk = ~clk;

   mii_rx_fcs_check u_mii_rx_fcs_check (
      .clk (clk), .rst_n (rst_n), .rx_dv (rx_dv), .rx_nib (rx_nib),
      .station_addr (STATION), .out_data (out_data), .out_valid (out_valid),
      .out_first (out_first), .frame_done (frame_done), .frame_ok (frame_ok),
      .crc_err_cnt (crc_err_cnt), .runt_cnt (runt_cnt),
      .align_err_cnt (align_err_cnt)
   );

   int vectors = 0;
   int fails   = 0;

   logic [7:0] frm    [0:1599];
   logic [7:0] rx_buf [0:4095];
   int rx_cnt    = 0;
   int first_idx = -1;
   int first_hits = 0;
   int done_seen = 0;
   logic last_ok = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (out_first) begin
               first_idx  = rx_cnt;
               first_hits = first_hits + 1;
            end
            rx_buf[rx_cnt % 4096] = out_data;
            rx_cnt = rx_cnt + 1;
         end
         if (frame_done) begin
            done_seen = done_seen + 1;
            last_ok   = frame_ok;
         end
      end
   end

   task automatic check(input bit cond, input string req, input string what,
                        input longint actual, input longint expected);
      vectors++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
      end
   endtask

   function automatic logic [31:0] bench_crc(input int n);
      logic [31:0] c = '1;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'h0, frm[i]};
         for (int b = 0; b < 8; b++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return c;
   endfunction

   task automatic build(input int nb, input logic [47:0] dst, input int seed,
                        input bit corrupt);
      logic [31:0] fcs;
      for (int i = 0; i < 6; i++) frm[i] = dst[47-8*i -: 8];
      for (int i = 6; i < 12; i++) frm[i] = 8'h10 + 8'(i);
      for (int i = 12; i < nb - 4; i++) frm[i] = 8'((i * 29 + seed) ^ (i >> 3));
      frm[12] = 8'h1E;
      fcs = ~bench_crc(nb - 4);
      for (int k = 0; k < 4; k++) frm[nb-4+k] = fcs[8*k +: 8];
      if (corrupt) frm[13] = frm[13] ^ 8'h01;
   endtask

   task automatic put_nib(input logic [3:0] n);
      @(negedge clk);
      rx_dv  = 1'b1;
      rx_nib = n;
   endtask

   // pre_mode 0: full preamble, 1: single 0x5 before 0xD, 2: broken preamble
   task automatic send(input int nb, input bit odd_nib, input int pre_mode,
                       output logic [2:0] dn);
      if (pre_mode == 1) put_nib(4'h5);
      else begin
         for (int i = 0; i < 15; i++) put_nib((pre_mode == 2 && i == 4) ? 4'h7 : 4'h5);
      end
      put_nib(4'hD);
      for (int i = 0; i < nb; i++) begin
         put_nib(frm[i][3:0]);
         put_nib(frm[i][7:4]);
      end
      if (odd_nib) put_nib(4'hA);
      @(negedge clk);
      rx_dv  = 1'b0;
      rx_nib = '0;
      @(posedge clk);
      @(negedge clk); dn[0] = frame_done;
      @(negedge clk); dn[1] = frame_done;
      @(negedge clk); dn[2] = frame_done;
      repeat (6) @(negedge clk);
   endtask

   // R3 R4 R5 R9: accepted frame to the station address
   task automatic t_good(input int nb, input logic [47:0] dst, input int pre_mode,
                         input string req);
      int base, dbase, mism, fh;
      logic [15:0] c0, r0, a0;
      logic [2:0] dn;
      base = rx_cnt; dbase = done_seen; fh = first_hits;
      c0 = crc_err_cnt; r0 = runt_cnt; a0 = align_err_cnt;
      build(nb, dst, nb, 1'b0);
      send(nb, 1'b0, pre_mode, dn);
      check(dn == 3'b010, "R9", "verdict timing", dn, 3'b010);
      check(done_seen - dbase == 1 && last_ok, req, "frame accepted", last_ok, 1);
      check(rx_cnt - base == nb - 4, "R4", "forwarded byte count", rx_cnt - base, nb - 4);
      mism = 0;
      for (int i = 0; i < nb - 4; i++) if (rx_buf[(base + i) % 4096] !== frm[i]) mism++;
      check(mism == 0, "R3", "payload byte mismatches", mism, 0);
      check(first_idx == base && first_hits - fh == 1, "R4", "first marker index",
            first_idx - base, 0);
      check(crc_err_cnt == c0 && runt_cnt == r0 && align_err_cnt == a0, "R5",
            "counters unchanged", crc_err_cnt + runt_cnt + align_err_cnt, c0 + r0 + a0);
   endtask

   // rejected frame: which counter moves (0 none, 1 crc, 2 runt, 3 align)
   task automatic t_reject(input int nb, input logic [47:0] dst, input bit corrupt,
                           input bit odd_nib, input int which, input string req);
      logic [15:0] c0, r0, a0;
      logic [2:0] dn;
      int dbase;
      dbase = done_seen;
      c0 = crc_err_cnt; r0 = runt_cnt; a0 = align_err_cnt;
      build(nb, dst, nb + 3, corrupt);
      send(nb, odd_nib, 0, dn);
      check(done_seen - dbase == 1 && !last_ok, req, "frame rejected", last_ok, 0);
      check(crc_err_cnt == c0 + 16'(which == 1), req, "crc_err_cnt", crc_err_cnt,
            c0 + 16'(which == 1));
      check(runt_cnt == r0 + 16'(which == 2), req, "runt_cnt", runt_cnt,
            r0 + 16'(which == 2));
      check(align_err_cnt == a0 + 16'(which == 3), req, "align_err_cnt", align_err_cnt,
            a0 + 16'(which == 3));
   endtask

   // R2: broken preamble is ignored entirely
   task automatic t_bad_preamble();
      logic [15:0] c0, r0, a0;
      logic [2:0] dn;
      int base, dbase;
      base = rx_cnt; dbase = done_seen;
      c0 = crc_err_cnt; r0 = runt_cnt; a0 = align_err_cnt;
      build(64, STATION, 5, 1'b0);
      send(64, 1'b0, 2, dn);
      check(done_seen == dbase, "R2", "no verdict after broken preamble",
            done_seen - dbase, 0);
      check(rx_cnt == base, "R2", "no bytes after broken preamble", rx_cnt - base, 0);
      check(crc_err_cnt == c0 && runt_cnt == r0 && align_err_cnt == a0, "R2",
            "counters unchanged", crc_err_cnt + runt_cnt + align_err_cnt, c0 + r0 + a0);
   endtask

   task automatic t_reset();
      check(!out_valid && !out_first && !frame_done && !frame_ok, "R1",
            "outputs idle", {out_valid, out_first, frame_done, frame_ok}, 0);
      check(crc_err_cnt == 0 && runt_cnt == 0 && align_err_cnt == 0, "R1",
            "counters zero", crc_err_cnt + runt_cnt + align_err_cnt, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_good(64, STATION, 0, "R5");        // exactly minimum length, R6 boundary
      t_good(64, BCAST, 0, "R8");          // broadcast always accepted
      t_good(300, STATION, 1, "R2");       // minimal preamble, long frame
      t_reject(64, FOREIGN, 1'b0, 1'b0, 0, "R8");
      t_reject(64, STATION, 1'b1, 1'b0, 1, "R5");
      t_reject(63, STATION, 1'b0, 1'b0, 2, "R6");
      t_reject(40, STATION, 1'b1, 1'b0, 2, "R10");
      t_reject(64, STATION, 1'b0, 1'b1, 3, "R7");
      t_reject(20, STATION, 1'b1, 1'b1, 3, "R10");
      t_bad_preamble();
      t_good(80, STATION, 0, "R5");        // recovery after dropped frame
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule